// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block runs one conversion on an eight-channel, 12-bit serial analog-to-digital converter that is clocked from the host side. A one-cycle `start` pulse, together with a channel number and two mode bits, launches the conversion. The block lowers chip select and shifts an eight-bit command out on the converter's data-in line. It keeps the serial clock running while the converter works and waits for the converter's strobe to fall. It then clocks in a sixteen-bit frame and returns the leading twelve bits as the result, with a one-cycle valid pulse.

The serial clock comes from a divider on the system clock, with a half period of `CLK_DIV` system cycles. The strobe and the converter's data line each pass through a two-flop synchroniser. Data are sampled on the internal tick that raises the serial clock, so `CLK_DIV` must be at least 4. A conversion whose strobe edge never arrives is abandoned after `TIMEOUT_SCLKS` serial clocks, and an error flag is raised.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A `start` pulse accepted while idle drives `adc_cs_n` low and `busy` high in the next cycle, with `adc_din` at 1. `busy` stays high until the cycle in which `adc_cs_n` returns high.
- R2: The command goes out MSB first as 1, chan[2], chan[1], chan[0], unipolar, single_ended, 1, 1. `adc_din` changes only at falling serial-clock edges, so each bit is stable at a rising edge.
- R3: `adc_sclk` is low whenever `adc_cs_n` is high. Its first rising edge comes `CLK_DIV` system cycles after chip select falls, and its period is `2*CLK_DIV` system cycles.
- R4: `adc_din` is low from the falling edge that follows the eighth command bit until the conversion ends.
- R5: After the command, the serial clock keeps running. Capture starts only after a falling edge of the synchronised strobe, and rising edges before that edge are not taken as data.
- R6: Exactly 16 rising edges follow the strobe edge. The result is the first 12 bits sampled, MSB first, and the last four bits are discarded.
- R7: At the falling tick after the sixteenth data edge, `adc_cs_n` returns high and `busy` falls. In the same cycle `result_valid` pulses for one cycle with the result.
- R8: The value on `adc_dout` during the command and wait phases has no effect on the result.
- R9: Suppose no strobe falling edge has been seen by the tick of the `TIMEOUT_SCLKS`-th rising edge in the wait phase. That edge is then not emitted: chip select goes high, the clock stays low, `timeout_err` is set and no `result_valid` is given. `timeout_err` holds until the next accepted start clears it.
- R10: A `start` pulse while `busy` is high is ignored. The command and result in progress are unchanged, and only one result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle conversion request |
| chan | input | 3 | Channel select placed in the command |
| unipolar | input | 1 | Unipolar (1) or bipolar (0) coding bit |
| single_ended | input | 1 | Single-ended (1) or differential (0) input bit |
| busy | output | 1 | Conversion in progress |
| result | output | 12 | Last conversion result |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| timeout_err | output | 1 | Last conversion abandoned for lack of strobe |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |
| adc_strobe | input | 1 | Converter strobe; a falling edge opens the data phase |

## Verification
The bench builds the block with `CLK_DIV = 4` and `TIMEOUT_SCLKS = 20`. A half period of four system cycles is the smallest the synchroniser latency allows, so the strobe edge and the data bits reach the sampling tick with no slack. The small timeout puts both sides of the boundary within a few hundred cycles: a strobe falling after 19 wait edges completes, and one needing 20 times out.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_DATA,
        ST_FIN
    } ctrl_state_e;

    localparam int CMD_BITS = 8;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        tick = 1'b0;
        if (!en) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(CLK_DIV - 1)) begin
            r_d.cnt = '0;
            tick = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.s2;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV       = 8,
    parameter int TIMEOUT_SCLKS = 64,
    parameter int RES_BITS      = 12,
    parameter int FRAME_BITS    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          chan,
    input  logic                unipolar,
    input  logic                single_ended,
    output logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic                timeout_err,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                adc_din,
    input  logic                adc_dout,
    input  logic                adc_strobe
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int TO_W  = $clog2(TIMEOUT_SCLKS + 1);

    typedef struct packed {
        ctrl_state_e            st;
        logic                   cs_n;
        logic                   sclk;
        logic [CMD_BITS-1:0]    cmd;
        logic [CNT_W-1:0]       bits;
        logic [TO_W-1:0]        to_cnt;
        logic [FRAME_BITS-1:0]  rx;
        logic [RES_BITS-1:0]    res;
        logic                   vld;
        logic                   err;
        logic                   stb_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic       tick;
    logic [1:0] sync_q;
    logic       stb_s, dout_s;
    logic       rise, fall, stb_fall;

    adc_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st != ST_IDLE),
        .tick (tick)
    );

    adc_in_sync #(.WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({adc_strobe, adc_dout}),
        .q    (sync_q)
    );

    assign stb_s  = sync_q[1];
    assign dout_s = sync_q[0];

    always_comb begin
        r_d          = r_q;
        r_d.vld      = 1'b0;
        r_d.stb_prev = stb_s;

        rise     = tick && !r_q.sclk;
        fall     = tick &&  r_q.sclk;
        stb_fall = r_q.stb_prev && !stb_s;

        if (tick) r_d.sclk = ~r_q.sclk;
        if (fall) r_d.cmd  = {r_q.cmd[CMD_BITS-2:0], 1'b0};

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_CMD;
                    r_d.cs_n = 1'b0;
                    r_d.sclk = 1'b0;
                    r_d.cmd  = {1'b1, chan, unipolar, single_ended, 2'b11};
                    r_d.bits = '0;
                    r_d.err  = 1'b0;
                end
            end
            ST_CMD: begin
                if (rise) begin
                    if (r_q.bits == CNT_W'(CMD_BITS - 1)) begin
                        r_d.st     = ST_WAIT;
                        r_d.bits   = '0;
                        r_d.to_cnt = '0;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (stb_fall) begin
                    r_d.st   = ST_DATA;
                    r_d.bits = '0;
                end else if (rise) begin
                    if (r_q.to_cnt == TO_W'(TIMEOUT_SCLKS - 1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.cs_n = 1'b1;
                        r_d.sclk = 1'b0;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.to_cnt = r_q.to_cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (rise) begin
                    r_d.rx = {r_q.rx[FRAME_BITS-2:0], dout_s};
                    if (r_q.bits == CNT_W'(FRAME_BITS - 1)) r_d.st = ST_FIN;
                    else                                     r_d.bits = r_q.bits + 1'b1;
                end
            end
            ST_FIN: begin
                if (fall) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.res  = r_q.rx[FRAME_BITS-1 -: RES_BITS];
                    r_d.vld  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign result       = r_q.res;
    assign result_valid = r_q.vld;
    assign timeout_err  = r_q.err;
    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign adc_din      = r_q.cmd[CMD_BITS-1];

    assert_busy_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !adc_cs_n);

    assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> adc_din);

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    assert_din_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA) |-> !adc_din);

    assert_bit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA) |-> (r_q.bits < CNT_W'(FRAME_BITS)));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_valid_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (adc_cs_n && !busy));

    assert_timeout_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (adc_cs_n && !result_valid));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int TMO        = 20;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  chan = '0;
    logic        unipolar = 1'b0;
    logic        single_ended = 1'b0;
    logic        busy, result_valid, timeout_err;
    logic [11:0] result;
    logic        adc_cs_n, adc_sclk, adc_din;
    logic        m_dout = 1'b1;
    logic        m_stb = 1'b0;

    int n_vec = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.CLK_DIV(DIV), .TIMEOUT_SCLKS(TMO), .RES_BITS(12), .FRAME_BITS(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .unipolar(unipolar),
        .single_ended(single_ended), .busy(busy), .result(result),
        .result_valid(result_valid), .timeout_err(timeout_err), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(m_dout), .adc_strobe(m_stb)
    );

    // Behavioural converter; drives 1 on dout outside its result window (stand-in for high impedance)
    logic [15:0] m_frame = '0;
    logic        m_stb_en = 1'b1;
    int          m_delay = 0;
    logic        m_prev = 1'b0;
    int          m_phase = 0, m_rises = 0, m_wrises = 0, m_drises = 0, m_wait = 0, m_idx = 0, m_dinhi = 0;
    logic [7:0]  m_cmd = '0;
    int          l_rises = 0, l_wrises = 0, l_drises = 0, l_dinhi = 0;
    logic [7:0]  l_cmd = '0;

    always @(adc_sclk or adc_cs_n) begin
        if (adc_cs_n) begin
            if (m_rises > 0) begin
                l_rises = m_rises; l_wrises = m_wrises; l_drises = m_drises;
                l_dinhi = m_dinhi; l_cmd = m_cmd;
            end
            m_phase = 0; m_rises = 0; m_wrises = 0; m_drises = 0; m_wait = 0;
            m_dinhi = 0; m_stb = 1'b0; m_dout = 1'b1;
        end else if (adc_sclk && !m_prev) begin
            m_rises++;
            if (m_rises <= 8) m_cmd = {m_cmd[6:0], adc_din};
            else if (adc_din) m_dinhi++;
            if (m_phase == 1) m_wrises++;
            if (m_phase == 2) m_drises++;
        end else if (!adc_sclk && m_prev) begin
            if (m_phase == 0 && m_rises == 8) begin
                m_phase = 1; m_stb = 1'b1; m_wait = 0;
            end else if (m_phase == 1 && m_stb_en) begin
                if (m_wait == m_delay) begin
                    m_phase = 2; m_stb = 1'b0; m_dout = m_frame[15]; m_idx = 14;
                end else begin
                    m_wait++;
                end
            end else if (m_phase == 2) begin
                m_dout = (m_idx >= 0) ? m_frame[m_idx] : 1'b1;
                m_idx--;
            end
        end
        m_prev = adc_sclk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [2:0] ch, input logic u, input logic s);
        @(negedge clk);
        chan = ch; unipolar = u; single_ended = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int nvld, output logic [11:0] res);
        nvld = 0; res = '0;
        for (int i = 0; i < 4000 && busy; i++) begin
            @(negedge clk);
            if (result_valid) begin nvld++; res = result; end
        end
    endtask

    task automatic t_reset();
        chk("R3", "reset cs_n", int'(adc_cs_n), 1);
        chk("R3", "reset sclk", int'(adc_sclk), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R7", "reset valid", int'(result_valid), 0);
        chk("R9", "reset err", int'(timeout_err), 0);
    endtask

    task automatic t_convert(input string tag, input logic [2:0] ch, input logic u, input logic s,
                             input logic [11:0] val, input logic [3:0] trail, input int dly);
        int nv; logic [11:0] r;
        m_frame = {val, trail}; m_stb_en = 1'b1; m_delay = dly;
        pulse_start(ch, u, s);
        chk("R1", {tag, " cs low"}, int'(adc_cs_n), 0);
        chk("R1", {tag, " busy"}, int'(busy), 1);
        chk("R1", {tag, " din start"}, int'(adc_din), 1);
        wait_idle(nv, r);
        chk("R7", {tag, " valid count"}, nv, 1);
        chk("R6", {tag, " result"}, int'(r), int'(val));
        chk("R7", {tag, " cs high"}, int'(adc_cs_n), 1);
        chk("R2", {tag, " command"}, int'(l_cmd), int'({1'b1, ch, u, s, 2'b11}));
        chk("R4", {tag, " din high after byte"}, l_dinhi, 0);
        chk("R5", {tag, " wait edges"}, l_wrises, dly + 1);
        chk("R6", {tag, " data edges"}, l_drises, 16);
        @(negedge clk);
        chk("R7", {tag, " valid width"}, int'(result_valid), 0);
        chk("R3", {tag, " sclk idle"}, int'(adc_sclk), 0);
    endtask

    task automatic t_period();
        time t0, t1, t2;
        int nv; logic [11:0] r;
        m_frame = 16'h1230; m_stb_en = 1'b1; m_delay = 1;
        @(negedge clk);
        chan = 3'd2; start = 1'b1;
        @(negedge adc_cs_n) t0 = $time;
        @(negedge clk) start = 1'b0;
        @(posedge adc_sclk) t1 = $time;
        @(posedge adc_sclk) t2 = $time;
        chk("R3", "first edge delay", int'((t1 - t0) / CLK_PERIOD), DIV);
        chk("R3", "sclk period", int'((t2 - t1) / CLK_PERIOD), 2 * DIV);
        wait_idle(nv, r);
        chk("R6", "period run result", int'(r), 12'h123);
        @(negedge clk);
    endtask

    task automatic t_timeout(input int dly, input logic en);
        int nv; logic [11:0] r;
        m_frame = 16'hABCD; m_stb_en = en; m_delay = dly;
        pulse_start(3'd3, 1'b0, 1'b0);
        wait_idle(nv, r);
        chk("R9", "timeout valid count", nv, 0);
        chk("R9", "timeout flag", int'(timeout_err), 1);
        chk("R9", "timeout cs high", int'(adc_cs_n), 1);
        chk("R9", "timeout total edges", l_rises, 8 + TMO - 1);
        @(negedge clk);
        chk("R9", "sclk low after timeout", int'(adc_sclk), 0);
    endtask

    task automatic t_err_clear();
        m_stb_en = 1'b1; m_delay = 0; m_frame = 16'h5550;
        pulse_start(3'd1, 1'b1, 1'b0);
        chk("R9", "flag cleared by start", int'(timeout_err), 0);
        begin
            int nv; logic [11:0] r;
            wait_idle(nv, r);
            chk("R9", "run after timeout", int'(r), 12'h555);
        end
        @(negedge clk);
    endtask

    task automatic t_busy_start();
        int nv; logic [11:0] r;
        m_frame = 16'h9C3F; m_stb_en = 1'b1; m_delay = 2;
        pulse_start(3'd6, 1'b1, 1'b1);
        repeat (30) @(negedge clk);
        start = 1'b1; chan = 3'd1; unipolar = 1'b0; single_ended = 1'b0;
        @(negedge clk) start = 1'b0;
        repeat (60) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_idle(nv, r);
        chk("R10", "single result", nv, 1);
        chk("R10", "result kept", int'(r), 12'h9C3);
        chk("R10", "command kept", int'(l_cmd), int'(8'b1_110_1_1_11));
        repeat (3 * DIV) @(negedge clk);
        chk("R10", "no new conversion", int'(busy), 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_convert("A", 3'd5, 1'b1, 1'b1, 12'hA5C, 4'hF, 0);
        t_convert("B", 3'd0, 1'b0, 1'b0, 12'hFFF, 4'h0, 3);
        // R8: dout held at 1 outside the window must not leak into a zero result
        t_convert("R8", 3'd7, 1'b0, 1'b1, 12'h000, 4'hF, 5);
        t_convert("C", 3'd4, 1'b1, 1'b0, 12'h801, 4'hA, 1);
        t_period();
        // R5 boundary: strobe falls after TMO-1 wait edges, still in time
        t_convert("R5 boundary", 3'd2, 1'b0, 1'b1, 12'h3E7, 4'h5, TMO - 2);
        t_timeout(TMO - 1, 1'b1);
        t_err_clear();
        t_timeout(0, 1'b0);
        t_err_clear();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule